// File: doc/BRIEF.md
# Capture/Compare Timer Channel Array

This block holds eight timer channels around one shared 16-bit free-running counter. Each channel owns a 16-bit register. A per-channel mode input makes the channel work in one of two ways. In capture mode, the channel stores the counter value when its input pin shows the chosen transition. In compare mode, the channel watches for the counter to reach the value that software wrote, then raises a sticky flag and toggles its output pin.

Software reaches the registers over a byte-wide bus. Each channel has a high-byte address and a low-byte address. Two one-byte holding registers make 16-bit accesses coherent, as long as the high byte goes first. A high-byte read freezes the matching low byte for the low-byte read that follows. A high-byte write is parked until the low-byte write, and the two bytes then land together as one 16-bit update.

Top module: `cc_timer_array`

## Requirements
- R1: The counter `cnt` resets to 0x0000. It advances by one on each clock edge where `cnt_en` is high, wraps from 0xFFFF to 0x0000, and holds its value while `cnt_en` is low.
- R2: Channel n's high byte sits at bus address 0x10 + 2n and its low byte at 0x11 + 2n. A read at any address below 0x10 returns 0x00, and a write there changes nothing.
- R3: After reset, every channel register reads 0x0000, and every `match_flag` and `cmp_out` bit is 0.
- R4: A high-byte read returns bits 15:8 of the register on `bus_rdata` in the same cycle. It also stores bits 7:0 in a holding byte. A low-byte read returns that holding byte, even if the register has changed since the high-byte read.
- R5: A high-byte write only loads a holding byte. A later low-byte write to a compare-mode channel (`mode` bit = 1) loads {holding byte, written byte} into that register in one step. Until that low-byte write, the register keeps its old value.
- R6: Bus writes to a channel whose `mode` bit is 0 (capture mode) leave its register unchanged.
- R7: The two bits of `edge_sel` for channel n, at [2n+1:2n], choose the capture transition: 00 none, 01 rising, 10 falling, 11 both.
- R8: `cap_in` passes through a two-flop synchronizer. A transition driven just before clock edge k is captured at edge k+2. The stored value is the counter value present just before edge k+2.
- R9: In compare mode, if `cnt_en` is high and the counter equals the register at a clock edge, that edge sets `match_flag[n]` and inverts `cmp_out[n]`. With `cnt_en` low, no match occurs.
- R10: A high `flag_clr[n]` clears `match_flag[n]` at the clock edge. If a match happens on the same edge, the set wins.
- R11: `bus_rdata` is 0x00 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counter advance enable |
| mode | input | 8 | Per-channel function: 1 compare, 0 capture |
| edge_sel | input | 16 | Two bits per channel selecting the capture transition |
| cap_in | input | 8 | Asynchronous capture inputs |
| flag_clr | input | 8 | Per-channel match flag clear |
| bus_addr | input | 5 | Byte bus address |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| cnt | output | 16 | Free-running counter value |
| match_flag | output | 8 | Sticky compare match flags |
| cmp_out | output | 8 | Compare toggle outputs |

## Verification
Some properties are checked by assertions on every cycle:
- the counter either steps by one or holds;
- flags stay set until cleared, and only rise after a cycle with the counter enabled in compare mode;
- an output toggle always comes with a set flag;
- read data is zero when idle or outside the map.

Other behaviour needs the bench's scenarios, which work out expected values from the counter:
- the exact captured counter value and the two-stage latency;
- the edge-select decode for every channel and every code;
- the high-then-low coherence of both holding bytes;
- dropped writes in capture mode;
- the exact edge at which a compare match fires.

// File: rtl/cc_timer_array.sv
module cc_timer_array #(
  parameter int NCH  = 8,
  parameter int AW   = 5,
  parameter int BASE = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [NCH-1:0]   mode,
  input  logic [2*NCH-1:0] edge_sel,
  input  logic [NCH-1:0]   cap_in,
  input  logic [NCH-1:0]   flag_clr,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  output logic [15:0]      cnt,
  output logic [NCH-1:0]   match_flag,
  output logic [NCH-1:0]   cmp_out
);
  localparam int CHB = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [AW-1:0] BASE_A = AW'(BASE);

  logic [15:0]     cnt_q;
  logic [15:0]     ccr [NCH];
  logic [NCH-1:0]  sy1, sy2, sy3;
  logic [7:0]      rd_hold, wr_hold;
  logic [AW-1:0]   off;
  logic [CHB-1:0]  ch_sel;
  logic            in_map, lo_byte;

  assign off     = bus_addr - BASE_A;
  assign ch_sel  = off[CHB:1];
  assign lo_byte = off[0];
  assign in_map  = (int'(bus_addr) >= BASE) && (int'(bus_addr) < BASE + 2*NCH);
  assign cnt     = cnt_q;

  assign bus_rdata = (bus_rd && in_map) ? (lo_byte ? rd_hold : ccr[ch_sel][15:8]) : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_q + 16'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_hold <= '0;
      wr_hold <= '0;
    end else begin
      if (bus_rd && in_map && !lo_byte) rd_hold <= ccr[ch_sel][7:0];
      if (bus_wr && in_map && !lo_byte) wr_hold <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1 <= '0;
      sy2 <= '0;
      sy3 <= '0;
    end else begin
      sy1 <= cap_in;
      sy2 <= sy1;
      sy3 <= sy2;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic rise, fall, hit, wr_lo, match;
    assign rise  = sy2[i] & ~sy3[i];
    assign fall  = ~sy2[i] & sy3[i];
    assign hit   = (edge_sel[2*i] & rise) | (edge_sel[2*i+1] & fall);
    assign wr_lo = bus_wr && in_map && lo_byte && (ch_sel == CHB'(i));
    assign match = mode[i] && cnt_en && (cnt_q == ccr[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ccr[i] <= '0;
      else if (mode[i]) begin
        if (wr_lo) ccr[i] <= {wr_hold, bus_wdata};
      end else if (hit) ccr[i] <= cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        match_flag[i] <= 1'b0;
        cmp_out[i]    <= 1'b0;
      end else begin
        if (match) match_flag[i] <= 1'b1;
        else if (flag_clr[i]) match_flag[i] <= 1'b0;
        if (match) cmp_out[i] <= ~cmp_out[i];
      end
    end
  end
endmodule

// File: rtl/cc_timer_array_chk.sv
module cc_timer_array_chk #(
  parameter int NCH  = 8,
  parameter int AW   = 5,
  parameter int BASE = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cnt_en,
  input logic [15:0]    cnt,
  input logic [NCH-1:0] mode,
  input logic [NCH-1:0] flag_clr,
  input logic [NCH-1:0] match_flag,
  input logic [NCH-1:0] cmp_out,
  input logic           bus_rd,
  input logic [AW-1:0]  bus_addr,
  input logic [7:0]     bus_rdata
);
  logic pv;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pv <= 1'b0;
    else pv <= 1'b1;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en |=> cnt == $past(cnt) + 16'd1); // R1
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> cnt == $past(cnt)); // R1
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == 8'h00); // R11
  AST_RDATA_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && int'(bus_addr) < BASE) |-> bus_rdata == 8'h00); // R2

  for (genvar i = 0; i < NCH; i++) begin : g_a
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (match_flag[i] && !flag_clr[i]) |=> match_flag[i]); // R10
    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (pv && $rose(match_flag[i])) |-> $past(mode[i] && cnt_en)); // R9
    AST_TOGGLE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (pv && cmp_out[i] != $past(cmp_out[i])) |-> match_flag[i]); // R9
  end
endmodule

bind cc_timer_array cc_timer_array_chk #(.NCH(NCH), .AW(AW), .BASE(BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt(cnt), .mode(mode),
  .flag_clr(flag_clr), .match_flag(match_flag), .cmp_out(cmp_out),
  .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/cc_timer_array_tb.sv
module cc_timer_array_tb;
  logic        clk = 0, rst_n = 0, cnt_en = 0, bus_wr = 0, bus_rd = 0;
  logic [7:0]  mode = 0, cap_in = 0, flag_clr = 0, bus_wdata = 0;
  logic [15:0] edge_sel = 0;
  logic [4:0]  bus_addr = 0;
  logic [7:0]  bus_rdata, match_flag, cmp_out;
  logic [15:0] cnt;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cc_timer_array u_dut (.clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .mode(mode),
    .edge_sel(edge_sel), .cap_in(cap_in), .flag_clr(flag_clr), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt(cnt), .match_flag(match_flag), .cmp_out(cmp_out));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr_byte(input logic [4:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1; tick(); bus_wr = 0;
  endtask

  task automatic rd_byte(input logic [4:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1; #1 d = bus_rdata; tick(); bus_rd = 0;
  endtask

  task automatic wr16(input int ch, input logic [15:0] v);
    wr_byte(5'(16 + 2*ch), v[15:8]); wr_byte(5'(17 + 2*ch), v[7:0]);
  endtask

  task automatic rd16(input int ch, output logic [15:0] v);
    logic [7:0] h, l;
    rd_byte(5'(16 + 2*ch), h); rd_byte(5'(17 + 2*ch), l); v = {h, l};
  endtask

  task automatic run(input int n);
    cnt_en = 1; repeat (n) tick(); cnt_en = 0;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
    end
  end

  initial begin
    logic [15:0] v, r0, c0, c1, vv;
    logic [7:0] b;
    logic o;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    // R3 reset state
    chk("R3 cnt", cnt, 0);
    chk("R3 flag", match_flag, 0);
    chk("R3 out", cmp_out, 0);
    for (int ch = 0; ch < 8; ch++) begin rd16(ch, v); chk("R3 reg", v, 0); end
    #1 chk("R11 idle rdata", bus_rdata, 0);

    // R2/R5 map and coherent writes
    mode = 8'hFF;
    for (int ch = 0; ch < 8; ch++) wr16(ch, 16'h1357 ^ 16'(ch * 16'h1111));
    for (int ch = 0; ch < 8; ch++) begin
      rd16(ch, v); chk("R2 map", v, 16'h1357 ^ 16'(ch * 16'h1111));
    end
    wr_byte(5'h05, 8'h77);
    rd_byte(5'h05, b); chk("R2 unmapped read", b, 0);
    rd16(2, v); chk("R2 unmapped write", v, 16'h1357 ^ 16'h2222);
    wr_byte(5'h16, 8'hAB);
    rd16(3, v); chk("R5 high alone", v, 16'h1357 ^ 16'h3333);
    wr_byte(5'h17, 8'hCD);
    rd16(3, v); chk("R5 commit", v, 16'hABCD);

    // R6 writes ignored in capture mode
    mode[5] = 0;
    wr16(5, 16'hFFFF);
    rd16(5, v); chk("R6 ignored", v, 16'h1357 ^ 16'h5555);

    // R4 read snapshot
    mode[1] = 0; edge_sel = 16'h0004;
    run(3);
    c0 = cnt; cap_in[1] = 1; repeat (4) tick();
    rd16(1, v); chk("R4 cap", v, c0);
    rd_byte(5'h12, b); chk("R4 high", b, c0[15:8]);
    cap_in[1] = 0; run(5); repeat (4) tick();
    cap_in[1] = 1; c1 = cnt; repeat (4) tick();
    rd_byte(5'h13, b); chk("R4 snapshot", b, c0[7:0]);
    rd16(1, v); chk("R4 new", v, c1);
    cap_in = 0; repeat (4) tick();

    // R7 edge select sweep
    mode = 0;
    for (int ch = 0; ch < 8; ch++) begin
      for (int s = 0; s < 4; s++) begin
        edge_sel = 0; edge_sel[2*ch +: 2] = 2'(s);
        run(3);
        rd16(ch, r0);
        cap_in[ch] = 1; repeat (4) tick(); c0 = cnt;
        rd16(ch, v); chk("R7 rise", v, s[0] ? c0 : r0);
        r0 = v; run(2);
        cap_in[ch] = 0; repeat (4) tick(); c0 = cnt;
        rd16(ch, v); chk("R7 fall", v, s[1] ? c0 : r0);
      end
    end

    // R8 capture latency with running counter
    edge_sel = 16'h0010;
    c0 = cnt; cnt_en = 1; cap_in[2] = 1;
    repeat (3) tick(); cnt_en = 0;
    rd16(2, v); chk("R8 latency", v, c0 + 16'd2);
    cap_in = 0; edge_sel = 0; repeat (4) tick();

    // R9 compare match
    mode = 8'hFF;
    flag_clr = 8'hFF; tick(); flag_clr = 0;
    vv = cnt + 16'd40;
    wr16(4, vv); wr16(6, vv + 16'd3);
    o = cmp_out[4];
    cnt_en = 1;
    while (cnt != vv) tick();
    chk("R9 before", {match_flag[4], cmp_out[4]}, {1'b0, o});
    tick();
    chk("R9 after", {match_flag[4], cmp_out[4]}, {1'b1, ~o});
    chk("R9 cnt", cnt, vv + 16'd1);
    o = cmp_out[6];
    tick(); tick();
    chk("R9 ch6 before", match_flag[6], 0);
    tick();
    chk("R9 ch6 after", {match_flag[6], cmp_out[6]}, {1'b1, ~o});
    cnt_en = 0;
    flag_clr[7] = 1; tick(); flag_clr = 0;
    wr16(7, cnt); repeat (3) tick();
    chk("R9 no match when stopped", match_flag[7], 0);
    cnt_en = 1; tick(); cnt_en = 0;
    chk("R9 match on enable", match_flag[7], 1);

    // R10 clear and set priority
    flag_clr[4] = 1; tick(); flag_clr = 0;
    chk("R10 clear", match_flag[4], 0);
    wr16(7, cnt);
    flag_clr[7] = 1; cnt_en = 1; tick(); flag_clr = 0; cnt_en = 0;
    chk("R10 set wins", match_flag[7], 1);

    // R1 hold and wrap
    c0 = cnt; repeat (3) tick();
    chk("R1 hold", cnt, c0);
    cnt_en = 1;
    while (cnt != 16'hFFFF) tick();
    tick(); cnt_en = 0;
    chk("R1 wrap", cnt, 0);

    done = 1;
    summary();
  end
endmodule